// File: doc/BRIEF.md
# GPIO Port with Peripheral Direction Override

An eight-pin general-purpose I/O port. Software sets and reads a data register and a direction register over a simple single-cycle bus. It also reads a synchronized view of the pad levels. Three on-chip peripherals can seize individual pins. They are a serial bus controller, a two-wire bus controller and a UART with separate transmit and receive enables. While a peripheral holds a pin, it decides the pad's drive and output-enable. The stored direction bit is kept as it was. Once the peripheral lets go, the stored bit governs the pin again.

Pad inputs pass through a two-stage synchronizer before they reach the readback paths and the peripheral receive outputs. A change of pad level or of direction can therefore take up to two clock cycles to appear in the readback. When two peripherals claim the same pin, a fixed order decides: serial bus controller first, then the two-wire controller, then the UART, then the register.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, the data and direction registers read 0x00 and every pad output-enable is 0.
- R2: With no peripheral enabled, pad_oe_o equals the stored direction bits (1 means output) and pad_o equals the data register. The register addresses are 0 for data, 1 for direction and 2 for the input view, which is read-only. Writes take effect at the clock edge, and reads are combinational.
- R3: Direction bit 3 is not implemented. It always reads 0, writes to it are ignored, and pin 3 never drives.
- R4: While sbc_en_i is 1, pin 7 drives sbc_tx_i with its output-enable at 1, and pin 6 has its output-enable at 0. The direction register readback does not change.
- R5: While twi_en_i is 1 and sbc_en_i is 0, pins 7 and 6 are open-drain. pad_o is 0 on both pins. The output-enable of pin 7 follows twi_pull_i[1], and the output-enable of pin 6 follows twi_pull_i[0]. The direction bits are untouched.
- R6: When sbc_en_i and twi_en_i are both 1, the serial bus controller's behaviour from R4 applies to pins 7 and 6.
- R7: While uart_tx_en_i is 1, pin 1 drives uart_tx_i with its output-enable at 1. While uart_rx_en_i is 1, pin 0 has its output-enable at 0.
- R8: When every peripheral is disabled, each pin's output-enable returns to its stored direction bit.
- R9: Reading address 2 returns pad_i as sampled two clock edges earlier.
- R10: Reading the data address returns the data register bit for pins currently acting as outputs and the synchronized pad bit for pins acting as inputs. Pins held by the two-wire controller count as inputs.
- R11: sbc_rx_o, uart_rx_o and twi_sense_o (bit 1 for pin 7, bit 0 for pin 6) carry the synchronized levels of pins 6, 0 and 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| sbc_en_i | input | 1 | Serial bus controller enable |
| sbc_tx_i | input | 1 | Serial bus controller transmit level |
| sbc_rx_o | output | 1 | Serial bus controller receive level |
| twi_en_i | input | 1 | Two-wire controller enable |
| twi_pull_i | input | 2 | Two-wire pull-low requests, pins 7 and 6 |
| twi_sense_o | output | 2 | Two-wire line levels, pins 7 and 6 |
| uart_tx_en_i | input | 1 | UART transmit enable |
| uart_tx_i | input | 1 | UART transmit level |
| uart_rx_en_i | input | 1 | UART receive enable |
| uart_rx_o | output | 1 | UART receive level |
| pad_i | input | 8 | Pad input levels |
| pad_o | output | 8 | Pad output levels |
| pad_oe_o | output | 8 | Pad output enables |

## Verification
The bench builds the port with its defaults: eight pins, an implemented-bit mask of 0xF7, the serial and two-wire controllers both on pins 7 and 6, and the UART on pins 1 and 0. Because the two controllers share pins, the priority rule can be exercised directly. The UART receive pin sits inside the data-readback mix, so a peripheral-forced input can be seen changing the data read. The synchronizer depth of two lets the bench observe the exact edge at which a new pad level appears.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IN   = 2'd2;
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int           W         = 8,
  parameter logic [W-1:0] IMPL_MASK = 8'hF7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      dir_eff_i,
  input  logic [W-1:0]      in_sync_i,
  output logic [W-1:0]      data_q_o,
  output logic [W-1:0]      dir_q_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] data_q, dir_q;
  logic         wr_en;

  assign wr_en = sel_i & wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (wr_en) begin
      if (addr_i == ADDR_DATA) data_q <= wdata_i;
      if (addr_i == ADDR_DIR)  dir_q  <= wdata_i & IMPL_MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      unique case (addr_i)
        ADDR_DATA: rdata_o = (data_q & dir_eff_i) | (in_sync_i & ~dir_eff_i);
        ADDR_DIR:  rdata_o = dir_q;
        ADDR_IN:   rdata_o = in_sync_i;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign data_q_o = data_q;
  assign dir_q_o  = dir_q;
endmodule

// File: rtl/gpio_ovr_resolve.sv
module gpio_ovr_resolve #(
  parameter int W       = 8,
  parameter int SBC_TX  = 7,
  parameter int SBC_RX  = 6,
  parameter int TWI_A   = 7,
  parameter int TWI_B   = 6,
  parameter int UART_TX = 1,
  parameter int UART_RX = 0
) (
  input  logic [W-1:0] dir_q_i,
  input  logic [W-1:0] data_q_i,
  input  logic         sbc_en_i,
  input  logic         sbc_tx_i,
  input  logic         twi_en_i,
  input  logic [1:0]   twi_pull_i,
  input  logic         uart_tx_en_i,
  input  logic         uart_tx_i,
  input  logic         uart_rx_en_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] dir_eff_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic o_b, oe_b, dir_b;
    // later claims win: sbc > twi > uart > register
    always_comb begin
      o_b   = data_q_i[i];
      oe_b  = dir_q_i[i];
      dir_b = dir_q_i[i];
      if (i == UART_RX && uart_rx_en_i) begin
        oe_b = 1'b0; dir_b = 1'b0;
      end
      if (i == UART_TX && uart_tx_en_i) begin
        o_b = uart_tx_i; oe_b = 1'b1; dir_b = 1'b1;
      end
      if (i == TWI_B && twi_en_i) begin
        o_b = 1'b0; oe_b = twi_pull_i[0]; dir_b = 1'b0;
      end
      if (i == TWI_A && twi_en_i) begin
        o_b = 1'b0; oe_b = twi_pull_i[1]; dir_b = 1'b0;
      end
      if (i == SBC_RX && sbc_en_i) begin
        oe_b = 1'b0; dir_b = 1'b0;
      end
      if (i == SBC_TX && sbc_en_i) begin
        o_b = sbc_tx_i; oe_b = 1'b1; dir_b = 1'b1;
      end
    end
    assign pad_o[i]     = o_b;
    assign pad_oe_o[i]  = oe_b;
    assign dir_eff_o[i] = dir_b;
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int           W         = 8,
  parameter logic [W-1:0] IMPL_MASK = 8'hF7,
  parameter int           SYNC_STG  = 2,
  parameter int           SBC_TX    = 7,
  parameter int           SBC_RX    = 6,
  parameter int           TWI_A     = 7,
  parameter int           TWI_B     = 6,
  parameter int           UART_TX   = 1,
  parameter int           UART_RX   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic              sbc_en_i,
  input  logic              sbc_tx_i,
  output logic              sbc_rx_o,
  input  logic              twi_en_i,
  input  logic [1:0]        twi_pull_i,
  output logic [1:0]        twi_sense_o,
  input  logic              uart_tx_en_i,
  input  logic              uart_tx_i,
  input  logic              uart_rx_en_i,
  output logic              uart_rx_o,
  input  logic [W-1:0]      pad_i,
  output logic [W-1:0]      pad_o,
  output logic [W-1:0]      pad_oe_o
);
  logic [W-1:0] in_sync, data_q, dir_q, dir_eff;

  gpio_ovr_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(in_sync)
  );

  gpio_ovr_regs #(.W(W), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk_i, .rst_ni, .sel_i, .wr_i, .addr_i, .wdata_i,
    .dir_eff_i(dir_eff), .in_sync_i(in_sync),
    .data_q_o(data_q), .dir_q_o(dir_q), .rdata_o
  );

  gpio_ovr_resolve #(
    .W(W), .SBC_TX(SBC_TX), .SBC_RX(SBC_RX), .TWI_A(TWI_A), .TWI_B(TWI_B),
    .UART_TX(UART_TX), .UART_RX(UART_RX)
  ) u_res (
    .dir_q_i(dir_q), .data_q_i(data_q),
    .sbc_en_i, .sbc_tx_i, .twi_en_i, .twi_pull_i,
    .uart_tx_en_i, .uart_tx_i, .uart_rx_en_i,
    .pad_o, .pad_oe_o, .dir_eff_o(dir_eff)
  );

  assign sbc_rx_o    = in_sync[SBC_RX];
  assign uart_rx_o   = in_sync[UART_RX];
  assign twi_sense_o = {in_sync[TWI_A], in_sync[TWI_B]};
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk
  import gpio_ovr_pkg::*;
#(
  parameter int           W         = 8,
  parameter logic [W-1:0] IMPL_MASK = 8'hF7,
  parameter int           SBC_TX    = 7,
  parameter int           SBC_RX    = 6,
  parameter int           TWI_A     = 7,
  parameter int           TWI_B     = 6,
  parameter int           UART_TX   = 1,
  parameter int           UART_RX   = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      rdata_o,
  input logic              sbc_en_i,
  input logic              sbc_tx_i,
  input logic              twi_en_i,
  input logic [1:0]        twi_pull_i,
  input logic              uart_tx_en_i,
  input logic              uart_tx_i,
  input logic              uart_rx_en_i,
  input logic [W-1:0]      pad_i,
  input logic [W-1:0]      pad_o,
  input logic [W-1:0]      pad_oe_o
);
  logic [1:0] edges_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edges_q <= '0;
    else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
  end

  a_r3_unimpl_never_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~IMPL_MASK) == '0 || uart_tx_en_i || sbc_en_i);

  a_r3_unimpl_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && addr_i == ADDR_DIR) |-> (rdata_o & ~IMPL_MASK) == '0);

  a_r4_sbc_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sbc_en_i |-> (pad_oe_o[SBC_TX] && pad_o[SBC_TX] == sbc_tx_i && !pad_oe_o[SBC_RX]));

  a_r5_twi_open_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (twi_en_i && !sbc_en_i) |-> (!pad_o[TWI_A] && !pad_o[TWI_B] &&
      pad_oe_o[TWI_A] == twi_pull_i[1] && pad_oe_o[TWI_B] == twi_pull_i[0]));

  a_r7_uart_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uart_tx_en_i |-> (pad_oe_o[UART_TX] && pad_o[UART_TX] == uart_tx_i));

  a_r7_uart_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uart_rx_en_i |-> !pad_oe_o[UART_RX]);

  a_r9_input_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q >= 2'd2 && sel_i && !wr_i && addr_i == ADDR_IN) |-> rdata_o == $past(pad_i, 2));
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(
  .W(W), .IMPL_MASK(IMPL_MASK), .SBC_TX(SBC_TX), .SBC_RX(SBC_RX),
  .TWI_A(TWI_A), .TWI_B(TWI_B), .UART_TX(UART_TX), .UART_RX(UART_RX)
) u_chk (
  .clk_i, .rst_ni, .sel_i, .wr_i, .addr_i, .rdata_o,
  .sbc_en_i, .sbc_tx_i, .twi_en_i, .twi_pull_i,
  .uart_tx_en_i, .uart_tx_i, .uart_rx_en_i,
  .pad_i, .pad_o, .pad_oe_o
);

// File: tb/sim_gpio_ovr_port.sv
`timescale 1ns/1ps
module sim_gpio_ovr_port;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       sel_i = 0, wr_i = 0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       sbc_en_i = 0, sbc_tx_i = 0, sbc_rx_o;
  logic       twi_en_i = 0;
  logic [1:0] twi_pull_i = '0, twi_sense_o;
  logic       uart_tx_en_i = 0, uart_tx_i = 0, uart_rx_en_i = 0, uart_rx_o;
  logic [7:0] pad_i = '0, pad_o, pad_oe_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_ovr_port u0 (.clk_i(clk), .*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    sel_i = 0; wr_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    sel_i = 1; wr_i = 0; addr_i = a;
    #0.5;
    d = rdata_o;
    sel_i = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    @(negedge clk);
    rd(2'd0, v); check("R1 data", v, 8'h00);
    rd(2'd1, v); check("R1 dir", v, 8'h00);
    check("R1 oe", pad_oe_o, 8'h00);
  endtask

  task automatic t_dir;
    logic [7:0] v;
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); check("R3 dir readback", v, 8'hF7);
    check("R2 oe", pad_oe_o, 8'hF7);
    check("R2 pad_o", pad_o, 8'h5A);
    wr(2'd1, 8'h08);
    rd(2'd1, v); check("R3 bit3 ignored", v, 8'h00);
    check("R3 pin3 oe", pad_oe_o, 8'h00);
    wr(2'd2, 8'hFF);
    rd(2'd1, v); check("R2 input addr write ignored", v, 8'h00);
  endtask

  task automatic t_sbc;
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF);
    @(negedge clk); sbc_en_i = 1; sbc_tx_i = 1; #0.5;
    check("R4 oe", pad_oe_o, 8'hB7);
    check("R4 pad_o", pad_o, 8'h80);
    rd(2'd1, v); check("R4 dir kept", v, 8'hF7);
    sbc_tx_i = 0; #0.5;
    check("R4 tx low", pad_o, 8'h00);
    @(negedge clk); sbc_en_i = 0; #0.5;
    check("R8 release sbc", pad_oe_o, 8'hF7);
  endtask

  task automatic t_twi;
    logic [7:0] v;
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h00);
    @(negedge clk); twi_en_i = 1; twi_pull_i = 2'b10; #0.5;
    check("R5 oe pull7", pad_oe_o, 8'h80);
    check("R5 pad_o low", pad_o, 8'h3F);
    twi_pull_i = 2'b01; #0.5;
    check("R5 oe pull6", pad_oe_o, 8'h40);
    rd(2'd1, v); check("R5 dir kept", v, 8'h00);
    // both enabled: serial bus controller owns 7 and 6
    twi_pull_i = 2'b11; sbc_en_i = 1; sbc_tx_i = 1; #0.5;
    check("R6 prio oe", pad_oe_o, 8'h80);
    check("R6 prio pad_o", pad_o, 8'hBF);
    @(negedge clk); sbc_en_i = 0; twi_en_i = 0; twi_pull_i = 2'b00; sbc_tx_i = 0; #0.5;
    check("R8 release twi", pad_oe_o, 8'h00);
  endtask

  task automatic t_uart;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    @(negedge clk); uart_tx_en_i = 1; uart_tx_i = 1; #0.5;
    check("R7 tx oe", pad_oe_o, 8'h02);
    check("R7 tx pad_o", pad_o, 8'h02);
    @(negedge clk); uart_tx_en_i = 0; uart_tx_i = 0;
    wr(2'd1, 8'hFF);
    @(negedge clk); uart_rx_en_i = 1; #0.5;
    check("R7 rx oe", pad_oe_o, 8'hF6);
    @(negedge clk); uart_rx_en_i = 0; #0.5;
    check("R8 release uart", pad_oe_o, 8'hF7);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    @(negedge clk); pad_i = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); pad_i = 8'hC1;
    @(posedge clk); #0.5;
    rd(2'd2, v); check("R9 one edge", v, 8'h00);
    @(posedge clk); #0.5;
    rd(2'd2, v); check("R9 two edges", v, 8'hC1);
    check("R11 sbc_rx", {7'd0, sbc_rx_o}, 8'h01);
    check("R11 uart_rx", {7'd0, uart_rx_o}, 8'h01);
    check("R11 twi_sense", {6'd0, twi_sense_o}, 8'h03);
  endtask

  task automatic t_data_read;
    logic [7:0] v;
    wr(2'd0, 8'hAA);
    wr(2'd1, 8'h0F);
    @(negedge clk); pad_i = 8'h55;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(2'd0, v); check("R10 mixed", v, 8'h52);
    uart_rx_en_i = 1; #0.5;
    rd(2'd0, v); check("R10 forced input", v, 8'h53);
    uart_rx_en_i = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1;
    t_reset();
    t_dir();
    t_sbc();
    t_twi();
    t_uart();
    t_sync();
    t_data_read();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule